// File: doc/BRIEF.md
# PCI Interrupt to ISA Request Router

This block steers four level-sensitive PCI interrupt lines onto sixteen ISA interrupt request outputs. Each PCI line has a 4-bit target number kept in a small byte-addressed configuration store. Every ISA output is driven high while any PCI line aimed at it is high. When several PCI lines share one target, they are wire-ORed together onto that output.

Software writes the routing bytes through a plain register port: address, data and write enable, sampled on the rising clock edge. A separate read address returns the stored byte combinationally. The target fields lie in a fixed, irregular set of nibbles spread over three consecutive bytes.

Interrupt inputs and outputs are active-high levels. The interrupts are levels and not a data stream, so no pin carries valid/ready: there is no back-pressure. The outputs are recomputed combinationally from the current inputs and the stored bytes. A register write is visible on the outputs from the clock edge that captures it.

Top module: `pci_isa_irq_router`

## Requirements
- R1: After reset, the bytes at 0x55, 0x56 and 0x57 read 0x00. Every PCI line is then aimed at ISA output 0, so `isa_irq_out` equals {15'b0, OR of `pci_irq_in`}.
- R2: The target of PCI line 0 is bits 7:4 of byte 0x55.
- R3: The target of PCI line 1 is bits 3:0 of byte 0x56. The target of PCI line 2 is bits 7:4 of byte 0x56.
- R4: The target of PCI line 3 is bits 7:4 of byte 0x57. Bits 3:0 of bytes 0x55 and 0x57 are stored but have no effect on any output.
- R5: Each bit j of `isa_irq_out` is the OR of every `pci_irq_in` bit whose target equals j. A shared output stays high until all of its contributing inputs are low.
- R6: A write with `cfg_we` high is captured on the rising edge. From that edge on, the outputs and the read-back use the new value. In the cycle before that edge, the old mapping still holds.
- R7: A write to any address other than 0x55 to 0x57 changes no stored byte. A read of any such address returns 0x00.
- R8: A read of 0x55, 0x56 or 0x57 returns all eight bits last written there, including the unused nibbles.
- R9: `isa_irq_out` follows `pci_irq_in` in the same cycle, with no register in the path. It is all zeros whenever every input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Write byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write enable, sampled on the rising edge |
| cfg_raddr | input | 8 | Read byte address |
| cfg_rdata | output | 8 | Read data for `cfg_raddr`, combinational |
| pci_irq_in | input | 4 | PCI interrupt levels, active high, already synchronous |
| isa_irq_out | output | 16 | ISA interrupt request levels, active high |

## Verification
A wrong stored nibble shows up at once in two places: on the read-back port, and as a misplaced output bit as soon as the affected PCI line is asserted. The bench keeps its own copy of the three bytes and recomputes the expected outputs every cycle, so a divergence is reported in the first cycle it exists. A bit lost in the OR tree is only visible while exactly that combination of inputs is held. For that reason the shared-target case releases the inputs one at a time and checks the output at each step.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int PCI_LINES = 4;
  localparam int ISA_LINES = 16;
  localparam int SEL_W     = $clog2(ISA_LINES);
  localparam int CFG_BYTES = 3;
  localparam logic [7:0] CFG_BASE = 8'h55;

  // byte offset (from CFG_BASE) holding each line's target, and which nibble
  localparam int LINE_BYTE [PCI_LINES] = '{0, 1, 1, 2};
  localparam bit LINE_HI   [PCI_LINES] = '{1'b1, 1'b0, 1'b1, 1'b1};

  typedef logic [SEL_W-1:0] isa_sel_t;
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_BYTES = 3,
  parameter logic [ADDR_W-1:0] BASE = 8'h55
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  rd_addr,
  output logic [DATA_W-1:0]                  rd_data,
  output logic [NUM_BYTES-1:0][DATA_W-1:0]   bytes_q
);
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_BYTES);

  logic [ADDR_W-1:0] wr_off, rd_off;
  logic              wr_hit, rd_hit;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  always_comb begin
    wr_off = wr_addr - BASE;
    rd_off = rd_addr - BASE;
    wr_hit = (wr_addr >= BASE) && (wr_off < SPAN);
    rd_hit = (rd_addr >= BASE) && (rd_off < SPAN);
    wr_idx = wr_off[IDX_W-1:0];
    rd_idx = rd_off[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_q <= '0;
    end else if (wr_en && wr_hit) begin
      bytes_q[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data = bytes_q[rd_idx];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit) |=> (bytes_q[$past(wr_idx)] == $past(wr_data))); // R6

  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> $stable(bytes_q)); // R7
endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 16,
  parameter int SW    = $clog2(N_OUT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IN-1:0]           irq_in,
  input  logic [N_IN-1:0][SW-1:0]   target,
  output logic [N_OUT-1:0]          irq_out
);
  genvar j, i;
  generate
    for (j = 0; j < N_OUT; j++) begin : g_out
      logic [N_IN-1:0] match;
      for (i = 0; i < N_IN; i++) begin : g_in
        assign match[i] = (32'(target[i]) == j) && irq_in[i];
      end
      assign irq_out[j] = |match;
    end
  endgenerate

  generate
    for (i = 0; i < N_IN; i++) begin : g_chk
      AST_LINE_REACHES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in[i] |-> irq_out[target[i]]); // R5
    end
  endgenerate

  AST_NO_EXTRA_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(irq_in)); // R5

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in == '0) |-> (irq_out == '0)); // R9
endmodule

// File: rtl/pci_isa_irq_router.sv
module pci_isa_irq_router
  import irq_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_raddr,
  output logic [7:0]           cfg_rdata,
  input  logic [PCI_LINES-1:0] pci_irq_in,
  output logic [ISA_LINES-1:0] isa_irq_out
);
  logic [CFG_BYTES-1:0][7:0]       cfg_bytes;
  logic [PCI_LINES-1:0][SEL_W-1:0] line_tgt;

  irq_route_cfg #(
    .ADDR_W(8), .DATA_W(8), .NUM_BYTES(CFG_BYTES), .BASE(CFG_BASE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(cfg_addr), .wr_data(cfg_wdata), .wr_en(cfg_we),
    .rd_addr(cfg_raddr), .rd_data(cfg_rdata),
    .bytes_q(cfg_bytes)
  );

  // fixed nibble layout: each line picks its byte and half from the package
  genvar k;
  generate
    for (k = 0; k < PCI_LINES; k++) begin : g_tgt
      if (LINE_HI[k]) begin : g_hi
        assign line_tgt[k] = cfg_bytes[LINE_BYTE[k]][7:4];
      end else begin : g_lo
        assign line_tgt[k] = cfg_bytes[LINE_BYTE[k]][3:0];
      end
    end
  endgenerate

  irq_route_fabric #(
    .N_IN(PCI_LINES), .N_OUT(ISA_LINES), .SW(SEL_W)
  ) u_fabric (
    .clk(clk), .rst_n(rst_n),
    .irq_in(pci_irq_in), .target(line_tgt), .irq_out(isa_irq_out)
  );
endmodule

// File: tb/test_pci_isa_irq_router.sv
`timescale 1ns/1ps
module test_pci_isa_irq_router;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] cfg_addr, cfg_wdata, cfg_raddr;
  logic cfg_we;
  logic [7:0] cfg_rdata;
  logic [3:0] pci_irq_in;
  logic [15:0] isa_irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pci_isa_irq_router i_pci_isa_irq_router (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .pci_irq_in(pci_irq_in), .isa_irq_out(isa_irq_out)
  );

  // behavioural reference
  logic [7:0] m_mem [0:2];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mem[0] <= 8'h00; m_mem[1] <= 8'h00; m_mem[2] <= 8'h00;
    end else if (cfg_we && cfg_addr >= 8'h55 && cfg_addr <= 8'h57) begin
      m_mem[cfg_addr - 8'h55] <= cfg_wdata;
    end
  end

  function automatic logic [15:0] model_out(input logic [3:0] in);
    int t [4];
    logic [15:0] r = '0;
    t[0] = int'(m_mem[0][7:4]);
    t[1] = int'(m_mem[1][3:0]);
    t[2] = int'(m_mem[1][7:4]);
    t[3] = int'(m_mem[2][7:4]);
    for (int n = 0; n < 4; n++) if (in[n]) r[t[n]] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    if (a >= 8'h55 && a <= 8'h57) return m_mem[a - 8'h55];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model, 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (rst_n === 1'b1 && !done) begin
      chk("R5 R9 cycle out", isa_irq_out, model_out(pci_irq_in));
      chk("R8 R7 cycle rdata", {8'h0, cfg_rdata}, {8'h0, model_rd(cfg_raddr)});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [3:0] v);
    @(negedge clk); pci_irq_in = v; #1;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); cfg_raddr = a; #1;
    chk(tag, {8'h0, cfg_rdata}, {8'h0, exp});
  endtask

  initial begin
    #150000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_addr = 0; cfg_wdata = 0; cfg_we = 0; cfg_raddr = 0; pci_irq_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd("R1 byte55", 8'h55, 8'h00);
    rd("R1 byte56", 8'h56, 8'h00);
    rd("R1 byte57", 8'h57, 8'h00);
    drive(4'b1010); chk("R1 all to 0", isa_irq_out, 16'h0001);
    drive(4'b0000); chk("R9 idle", isa_irq_out, 16'h0000);

    // R2 line 0 from 0x55 high nibble; low nibble 3 unused (R4)
    wr(8'h55, 8'hA3);
    drive(4'b0001); chk("R2 line0 to 10", isa_irq_out, 16'h0400);
    chk("R4 low nibble 55 unused", {15'h0, isa_irq_out[3]}, 16'h0);
    rd("R8 readback 55", 8'h55, 8'hA3);

    // R3 line1/line2
    wr(8'h56, 8'h5C);
    drive(4'b0010); chk("R3 line1 to 12", isa_irq_out, 16'h1000);
    drive(4'b0100); chk("R3 line2 to 5", isa_irq_out, 16'h0020);

    // R4 line3, low nibble E unused
    wr(8'h57, 8'h7E);
    drive(4'b1000); chk("R4 line3 to 7", isa_irq_out, 16'h0080);
    rd("R8 readback 57", 8'h57, 8'h7E);
    drive(4'b1111); chk("R9 all lines", isa_irq_out, 16'h14A0);

    // R5 shared target: lines 1,2,3 on output 7
    drive(4'b0000);
    wr(8'h56, 8'h77);
    drive(4'b1110); chk("R5 shared all", isa_irq_out, 16'h0080);
    drive(4'b1100); chk("R5 shared minus1", isa_irq_out, 16'h0080);
    drive(4'b1000); chk("R5 shared minus2", isa_irq_out, 16'h0080);
    drive(4'b0000); chk("R5 shared released", isa_irq_out, 16'h0000);
    drive(4'b0110); chk("R5 shared pair", isa_irq_out, 16'h0080);
    drive(4'b0011); chk("R5 mixed", isa_irq_out, 16'h0480);

    // R6 remap timing: line0 held high, move 10 -> 2
    drive(4'b0001);
    @(negedge clk); cfg_addr = 8'h55; cfg_wdata = 8'h20; cfg_we = 1'b1; #1;
    chk("R6 before edge old", isa_irq_out, 16'h0400);
    @(posedge clk); #1;
    chk("R6 after edge new", isa_irq_out, 16'h0004);
    @(negedge clk); cfg_we = 1'b0;

    // R7 misses ignored
    wr(8'h54, 8'hFF); wr(8'h58, 8'hFF); wr(8'h00, 8'hFF); wr(8'hFF, 8'h11);
    rd("R7 55 kept", 8'h55, 8'h20);
    rd("R7 56 kept", 8'h56, 8'h77);
    rd("R7 57 kept", 8'h57, 8'h7E);
    rd("R7 read 54", 8'h54, 8'h00);
    rd("R7 read 58", 8'h58, 8'h00);
    drive(4'b1111); chk("R7 routing kept", isa_irq_out, 16'h0084);
    drive(4'b0000);

    repeat (2) @(posedge clk);
    #4;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule